// File: doc/BRIEF.md
# Endian-Aware Flash Data Port Packer

This block connects a 32-bit processor-side data register to the I/O bus of an external NAND flash device whose bus is either 8 or 16 bits wide. A request names the direction, the access size (byte, half-word or word), the bus width and the byte order. The block then runs as many flash I/O cycles as that combination needs.

On a read, each bus value returned by the flash is placed into a lane of the 32-bit result. The lane depends on the cycle number and the byte order. On a write, the 32-bit value is cut into the same lanes and driven out one cycle at a time. Each I/O cycle holds its read or write strobe for a programmable number of clocks. The command and address phases of the flash protocol belong to other logic.

The sequencer has four states:
- IDLE: waits for a request. On a legal request it takes the "accept" transition to STROBE. An illegal request raises an error pulse and the block stays in IDLE.
- STROBE: drives one I/O strobe. When the strobe width is reached, it takes "next" to GAP if more cycles remain, or "last" to FINISH.
- GAP: holds one clock with no strobe, advances the cycle index, and takes "resume" back to STROBE.
- FINISH: pulses done for one clock and takes "retire" back to IDLE.

Top module: `nand_lane_packer`

## Requirements
- R1: On an 8-bit bus, a little-endian word read (size code 2, `big_endian`=0) runs 4 I/O cycles. Cycles 1, 2, 3 and 4 land in `rd_data` bits [7:0], [15:8], [23:16] and [31:24] in that order.
- R2: On an 8-bit bus, a big-endian word read runs 4 I/O cycles. Cycles 1, 2, 3 and 4 land in bits [31:24], [23:16], [15:8] and [7:0] in that order.
- R3: On an 8-bit bus, a half-word read (size code 1) runs 2 I/O cycles.
  - Little-endian puts cycle 1 in [7:0] and cycle 2 in [15:8].
  - Big-endian puts cycle 1 in [15:8] and cycle 2 in [7:0].
  - Bits [31:16] read as zero.
- R4: On an 8-bit bus, a byte read (size code 0) runs 1 I/O cycle into [7:0] for either byte order. Bits [31:8] read as zero. Only `io_din[7:0]` is used on an 8-bit bus.
- R5: On a 16-bit bus (`bus_wide`=1), a word read runs 2 I/O cycles.
  - Little-endian puts cycle 1 in [15:0] and cycle 2 in [31:16].
  - Big-endian puts cycle 1 in [31:16] and cycle 2 in [15:0].
- R6: On a 16-bit bus, a half-word read runs 1 I/O cycle into [15:0] for either byte order. Bits [31:16] read as zero.
- R7: The following requests are illegal: a byte access on a 16-bit bus, and size code 3. An illegal request raises `err` for exactly one clock, on the clock after the request. It starts no I/O strobe and leaves `busy` low.
- R8: Each I/O cycle holds `io_re` (reads) or `io_we` (writes) high for exactly N consecutive clocks. N is `strobe_len`, and a value of 0 counts as 1. Consecutive strobes are separated by at least one low clock. `io_re` and `io_we` are never high together.
- R9: `busy` rises on the clock after a request is accepted and stays high until the last strobe ends. `done` is then high for exactly one clock with `busy` low. `rd_data` holds the result from `done` until the next accepted request.
- R10: On a write, `io_dout` carries, during each strobe, the lane of `wr_data` that a read of the same setup would fill in that cycle. On an 8-bit bus, `io_dout[15:8]` is zero.
- R11: A request made while `busy` is high is ignored. The running access keeps its cycle count, direction and result.
- R12: During a read strobe, `io_din` is captured on the last clock of the strobe only. Values present on earlier clocks of that strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wide | input | 1 | 1 = 16-bit flash bus, 0 = 8-bit |
| big_endian | input | 1 | 1 = big-endian lane order |
| wr_data | input | 32 | Register value to write |
| strobe_len | input | 4 | Strobe width in clocks (0 acts as 1) |
| io_din | input | 16 | Data from the flash bus |
| io_dout | output | 16 | Data to the flash bus |
| io_re | output | 1 | Read strobe |
| io_we | output | 1 | Write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock illegal-request pulse |
| rd_data | output | 32 | Assembled read result |

## Verification
Reads are tried on both bus widths and all sizes, in both byte orders. Distinct byte values per cycle expose any swapped or duplicated lane, and a wrong cycle count shows in the number of strobes seen. During long strobes the flash model presents a poison value on every clock but the last, which separates correct late capture from early capture. Write tests reuse the same matrix on `io_dout`. An extra request is fired mid-access to show that it changes neither the strobe count nor the result. The illegal size combinations show up as an error pulse with no strobe activity.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/nlp_plan.sv
module nlp_plan
    import nlp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 3
) (
    input  logic [1:0]       size_i,
    input  logic             wide_i,
    output logic             legal_o,
    output logic [CNT_W-1:0] n_cyc_o
);
    localparam int NARROW_W  = IO_W / 2;
    localparam int WORD_NARW = DATA_W / NARROW_W;
    localparam int WORD_WIDE = DATA_W / IO_W;

    logic [CNT_W-1:0] word_n;

    always_comb begin
        word_n  = wide_i ? CNT_W'(WORD_WIDE) : CNT_W'(WORD_NARW);
        legal_o = 1'b1;
        n_cyc_o = '0;
        unique case (size_e'(size_i))
            SZ_BYTE: begin
                legal_o = !wide_i;
                n_cyc_o = word_n >> 2;
            end
            SZ_HALF: n_cyc_o = word_n >> 1;
            SZ_WORD: n_cyc_o = word_n;
            SZ_RSVD: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nlp_seq.sv
module nlp_seq
    import nlp_pkg::*;
#(
    parameter int STROBE_W = 4,
    parameter int CNT_W    = 3,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                legal_i,
    input  logic                wr_i,
    input  logic [CNT_W-1:0]    n_i,
    input  logic [STROBE_W-1:0] len_i,
    output logic                start_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [CNT_W-1:0]    n_o,
    output logic                sample_o,
    output logic                io_re,
    output logic                io_we,
    output logic                busy,
    output logic                done,
    output logic                err
);
    seq_state_e state_q, state_d;

    logic [STROBE_W-1:0] cnt_q;
    logic [STROBE_W-1:0] len_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    n_q;
    logic                wr_q;
    logic                err_q;
    logic                last_clk;
    logic                last_cyc;
    logic                in_idle;

    assign in_idle  = (state_q == ST_IDLE);
    assign start_o  = in_idle && req_i && legal_i;
    assign last_clk = (cnt_q == len_q - STROBE_W'(1));
    assign last_cyc = (CNT_W'(idx_q) == n_q - CNT_W'(1));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_o) state_d = ST_STROBE;
            ST_STROBE: if (last_clk) state_d = last_cyc ? ST_FINISH : ST_GAP;
            ST_GAP:    state_d = ST_STROBE;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // access context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= STROBE_W'(1);
            idx_q <= '0;
            n_q   <= '0;
            wr_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= in_idle && req_i && !legal_i;
            if (start_o) begin
                cnt_q <= '0;
                idx_q <= '0;
                n_q   <= n_i;
                wr_q  <= wr_i;
                len_q <= (len_i == '0) ? STROBE_W'(1) : len_i;
            end else if (state_q == ST_STROBE) begin
                if (!last_clk) cnt_q <= cnt_q + STROBE_W'(1);
            end else if (state_q == ST_GAP) begin
                cnt_q <= '0;
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        io_re    = 1'b0;
        io_we    = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        sample_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_STROBE: begin
                busy     = 1'b1;
                io_re    = !wr_q;
                io_we    = wr_q;
                sample_o = !wr_q && last_clk;
            end
            ST_GAP:    busy = 1'b1;
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign err   = err_q;
    assign idx_o = idx_q;
    assign n_o   = n_q;

    // strobe width checker
    logic [STROBE_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (io_re || io_we) run_q <= run_q + (STROBE_W+1)'(1);
        else                     run_q <= '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_re && io_we)); // R8
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_re || io_we) |-> (run_q == {1'b0, len_q})); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !io_re && !io_we)); // R7
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_i) |=> !err); // R11

endmodule

// File: rtl/nlp_lanes.sv
module nlp_lanes #(
    parameter int DATA_W = 32,
    parameter int IO_W   = 16,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wide_i,
    input  logic              big_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  n_i,
    input  logic              sample_i,
    input  logic              we_i,
    input  logic [IO_W-1:0]   io_din,
    output logic [IO_W-1:0]   io_dout,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NARROW_W = IO_W / 2;
    localparam int NLANE    = DATA_W / NARROW_W;
    localparam int SH_W     = $clog2(DATA_W);

    logic              wide_q;
    logic              big_q;
    logic [DATA_W-1:0] wdat_q;
    logic [IDX_W-1:0]  lane;
    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] wr_shift;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            big_q  <= 1'b0;
            wdat_q <= '0;
        end else if (start_i) begin
            wide_q <= wide_i;
            big_q  <= big_i;
            wdat_q <= wr_data_i;
        end
    end

    // byte order: reverse cycle index within the access
    assign lane = big_q ? (IDX_W'(n_i - CNT_W'(1)) - idx_i) : idx_i;

    always_comb begin
        shamt    = wide_q ? SH_W'(lane) * SH_W'(IO_W) : SH_W'(lane) * SH_W'(NARROW_W);
        wr_shift = wdat_q >> shamt;
        if (wide_q) io_dout = wr_shift[IO_W-1:0];
        else        io_dout = {{(IO_W-NARROW_W){1'b0}}, wr_shift[NARROW_W-1:0]};
    end

    for (genvar b = 0; b < NLANE; b++) begin : g_lane
        logic                hit;
        logic [NARROW_W-1:0] src;
        logic [NARROW_W-1:0] byte_q;

        assign hit = wide_q ? (lane == IDX_W'(b / 2)) : (lane == IDX_W'(b));
        assign src = wide_q ? io_din[NARROW_W*(b%2) +: NARROW_W] : io_din[NARROW_W-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n)                byte_q <= '0;
            else if (start_i)          byte_q <= '0;
            else if (sample_i && hit)  byte_q <= src;
        end

        assign rd_data[NARROW_W*b +: NARROW_W] = byte_q;
    end

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wide_q) |-> (io_dout[IO_W-1:NARROW_W] == '0)); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_i && !start_i) |=> $stable(rd_data)); // R9
    AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |-> (CNT_W'(lane) < n_i)); // R1

endmodule

// File: rtl/nand_lane_packer.sv
module nand_lane_packer
    import nlp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IO_W     = 16,
    parameter int STROBE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                bus_wide,
    input  logic                big_endian,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [STROBE_W-1:0] strobe_len,
    input  logic [IO_W-1:0]     io_din,
    output logic [IO_W-1:0]     io_dout,
    output logic                io_re,
    output logic                io_we,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int NARROW_W = IO_W / 2;
    localparam int MAX_CYC  = DATA_W / NARROW_W;
    localparam int IDX_W    = $clog2(MAX_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             legal;
    logic [CNT_W-1:0] n_req;
    logic [CNT_W-1:0] n_cur;
    logic [IDX_W-1:0] idx;
    logic             start;
    logic             sample;

    nlp_plan #(.DATA_W(DATA_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_plan (
        .size_i  (req_size),
        .wide_i  (bus_wide),
        .legal_o (legal),
        .n_cyc_o (n_req)
    );

    nlp_seq #(.STROBE_W(STROBE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_valid),
        .legal_i  (legal),
        .wr_i     (req_write),
        .n_i      (n_req),
        .len_i    (strobe_len),
        .start_o  (start),
        .idx_o    (idx),
        .n_o      (n_cur),
        .sample_o (sample),
        .io_re    (io_re),
        .io_we    (io_we),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    nlp_lanes #(.DATA_W(DATA_W), .IO_W(IO_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .wr_data_i (wr_data),
        .wide_i    (bus_wide),
        .big_i     (big_endian),
        .idx_i     (idx),
        .n_i       (n_cur),
        .sample_i  (sample),
        .we_i      (io_we),
        .io_din    (io_din),
        .io_dout   (io_dout),
        .rd_data   (rd_data)
    );

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && req_valid && legal) |=> busy); // R9

endmodule

// File: tb/nand_lane_packer_tb_top.sv
module nand_lane_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        bus_wide = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  strobe_len = 4'd1;
    logic [15:0] io_din = '0;
    logic [15:0] io_dout;
    logic        io_re, io_we, busy, done, err;
    logic [31:0] rd_data;

    always #10 clk = ~clk; // 50 MHz

    nand_lane_packer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .bus_wide(bus_wide), .big_endian(big_endian),
        .wr_data(wr_data), .strobe_len(strobe_len), .io_din(io_din),
        .io_dout(io_dout), .io_re(io_re), .io_we(io_we), .busy(busy),
        .done(done), .err(err), .rd_data(rd_data)
    );

    typedef struct {
        bit          wr;
        logic [31:0] rd;
        int          ncyc;
        string       tag;
    } acc_exp_t;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } wr_exp_t;

    acc_exp_t    q_acc[$];
    wr_exp_t     q_wr[$];
    int          errors = 0;
    int          checks = 0;
    int          cur_len = 1;
    logic [15:0] flash_rd [4];
    int          rd_idx = 0;
    int          run = 0;
    int          strobes = 0;
    int          done_cnt = 0;
    bit          prev_strb = 0;
    bit          prev_busy = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // flash model and monitor
    always @(negedge clk) begin
        bit strb;
        strb = io_re || io_we;
        if (rst_n) begin
            if (strb) begin
                run++;
                if (io_re) begin
                    // R12: poison on all but the last strobe clock
                    if (run == cur_len) begin
                        io_din = flash_rd[rd_idx % 4];
                        rd_idx++;
                    end else begin
                        io_din = 16'hDEAD;
                    end
                end
                if (io_we && run == 1) begin
                    if (q_wr.size() == 0) chk(0, "R10 unexpected write cycle", {16'h0, io_dout}, 0);
                    else begin
                        wr_exp_t w;
                        w = q_wr.pop_front();
                        chk(io_dout == w.d, w.tag, {16'h0, io_dout}, {16'h0, w.d});
                    end
                end
            end else if (prev_strb) begin
                chk(run == cur_len, "R8 strobe width", run, cur_len);
                strobes++;
                run = 0;
            end
            if (done) begin
                chk(!busy && prev_busy, "R9 done after busy", {30'h0, busy, prev_busy}, 32'h1);
                if (q_acc.size() == 0) chk(0, "R9 unexpected done", 0, 1);
                else begin
                    acc_exp_t e;
                    e = q_acc.pop_front();
                    chk(strobes == e.ncyc, {e.tag, " cycle count"}, strobes, e.ncyc);
                    if (!e.wr) chk(rd_data == e.rd, {e.tag, " read data"}, rd_data, e.rd);
                end
                strobes = 0;
                done_cnt++;
            end
        end
        prev_strb = strb;
        prev_busy = busy;
    end

    function automatic int ncyc_of(input logic [1:0] sz, input bit wide);
        int word;
        word = wide ? 2 : 4;
        case (sz)
            2'd0: return word / 4;
            2'd1: return word / 2;
            default: return word;
        endcase
    endfunction

    task automatic access(input bit wr, input logic [1:0] sz, input bit wide, input bit big,
                          input logic [31:0] wd, input logic [3:0] len,
                          input logic [15:0] d0, input logic [15:0] d1,
                          input logic [15:0] d2, input logic [15:0] d3,
                          input string tag);
        acc_exp_t e;
        int n, unit, start_cnt;
        logic [31:0] mask;
        logic [15:0] din [4];
        din = '{d0, d1, d2, d3};
        n = ncyc_of(sz, wide);
        unit = wide ? 16 : 8;
        mask = wide ? 32'hFFFF : 32'hFF;
        e.wr = wr; e.rd = '0; e.ncyc = n; e.tag = tag;
        for (int i = 0; i < n; i++) begin
            int p;
            p = big ? (n - 1 - i) : i;
            if (wr) begin
                wr_exp_t w;
                w.d = 16'((wd >> (p * unit)) & mask);
                w.tag = {tag, " write lane"};
                q_wr.push_back(w);
            end else begin
                e.rd = e.rd | ((32'(din[i]) & mask) << (p * unit));
            end
        end
        q_acc.push_back(e);
        flash_rd = din;
        rd_idx = 0;
        cur_len = (len == 0) ? 1 : int'(len);
        start_cnt = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; bus_wide = wide;
        big_endian = big; wr_data = wd; strobe_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        wait (done_cnt == start_cnt + 1);
        @(negedge clk);
    endtask

    task automatic illegal(input logic [1:0] sz, input bit wide, input string tag);
        int s0;
        s0 = strobes;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = sz; bus_wide = wide; big_endian = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err && !busy && !io_re && !io_we, tag, {29'h0, err, busy, io_re}, 32'h4);
        @(negedge clk);
        chk(!err, {tag, " single pulse"}, {31'h0, err}, 0);
        repeat (4) @(negedge clk);
        chk(strobes == s0 && !busy, {tag, " no io"}, strobes, s0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !io_re && !io_we && rd_data == 0,
            "reset state", {27'h0, busy, done, err, io_re, io_we}, 0);

        // R1, R2 narrow word reads
        access(0, 2'd2, 0, 0, 0, 4'd2, 16'h11, 16'h22, 16'h33, 16'h44, "R1 narrow LE word");
        access(0, 2'd2, 0, 1, 0, 4'd1, 16'h11, 16'h22, 16'h33, 16'h44, "R2 narrow BE word");
        // upper byte of io_din ignored on narrow bus (R4)
        access(0, 2'd2, 0, 0, 0, 4'd3, 16'hF0A1, 16'hF0B2, 16'hF0C3, 16'hF0D4, "R4 narrow upper din ignored");
        // R3 narrow half
        access(0, 2'd1, 0, 0, 0, 4'd1, 16'hAB, 16'hCD, 16'h0, 16'h0, "R3 narrow LE half");
        access(0, 2'd1, 0, 1, 0, 4'd2, 16'hAB, 16'hCD, 16'h0, 16'h0, "R3 narrow BE half");
        // R4 byte
        access(0, 2'd0, 0, 0, 0, 4'd1, 16'h5A, 16'h0, 16'h0, 16'h0, "R4 narrow byte LE");
        access(0, 2'd0, 0, 1, 0, 4'd4, 16'hC7, 16'h0, 16'h0, 16'h0, "R4 narrow byte BE");
        // R5, R6 wide
        access(0, 2'd2, 1, 0, 0, 4'd3, 16'h1234, 16'h5678, 16'h0, 16'h0, "R5 wide LE word");
        access(0, 2'd2, 1, 1, 0, 4'd2, 16'h1234, 16'h5678, 16'h0, 16'h0, "R5 wide BE word");
        access(0, 2'd1, 1, 0, 0, 4'd1, 16'hBEEF, 16'h0, 16'h0, 16'h0, "R6 wide LE half");
        access(0, 2'd1, 1, 1, 0, 4'd5, 16'hCAFE, 16'h0, 16'h0, 16'h0, "R6 wide BE half");
        // R8 zero length acts as one, long strobe (R12 poison)
        access(0, 2'd2, 0, 0, 0, 4'd0, 16'h01, 16'h02, 16'h03, 16'h04, "R8 zero strobe length");
        access(0, 2'd2, 1, 0, 0, 4'd7, 16'hA5A5, 16'h5A5A, 16'h0, 16'h0, "R12 late capture");
        // R10 writes
        access(1, 2'd2, 0, 0, 32'hA1B2C3D4, 4'd2, 0, 0, 0, 0, "R10 narrow LE word write");
        access(1, 2'd2, 0, 1, 32'hA1B2C3D4, 4'd1, 0, 0, 0, 0, "R10 narrow BE word write");
        access(1, 2'd1, 0, 1, 32'hA1B2C3D4, 4'd1, 0, 0, 0, 0, "R10 narrow BE half write");
        access(1, 2'd0, 0, 0, 32'hA1B2C3D4, 4'd1, 0, 0, 0, 0, "R10 narrow byte write");
        access(1, 2'd2, 1, 1, 32'hA1B2C3D4, 4'd3, 0, 0, 0, 0, "R10 wide BE word write");
        access(1, 2'd1, 1, 0, 32'hA1B2C3D4, 4'd2, 0, 0, 0, 0, "R10 wide LE half write");
        chk(rd_data == 0, "R9 read result cleared by later access", rd_data, 0);

        // R7 illegal requests
        illegal(2'd0, 1, "R7 byte on wide bus");
        illegal(2'd3, 0, "R7 reserved size");

        // R11 request while busy is ignored
        begin
            acc_exp_t e;
            int s0;
            e.wr = 0; e.rd = 32'h99887766; e.ncyc = 4; e.tag = "R11 busy request ignored";
            q_acc.push_back(e);
            flash_rd = '{16'h66, 16'h77, 16'h88, 16'h99};
            rd_idx = 0; cur_len = 3; s0 = done_cnt;
            @(negedge clk);
            req_valid = 1; req_write = 0; req_size = 2'd2; bus_wide = 0; big_endian = 0; strobe_len = 4'd3;
            @(negedge clk);
            req_valid = 0;
            repeat (4) @(negedge clk);
            req_valid = 1; req_write = 1; req_size = 2'd1; bus_wide = 1; big_endian = 1;
            strobe_len = 4'd1; wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            req_valid = 0;
            wait (done_cnt == s0 + 1);
            @(negedge clk);
            chk(!busy && !err, "R11 idle after ignored request", {30'h0, busy, err}, 0);
            chk(rd_data == 32'h99887766, "R11 result held after done", rd_data, 32'h99887766);
        end
        chk(q_wr.size() == 0 && q_acc.size() == 0, "R10 all expected items consumed",
            q_wr.size() + q_acc.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule